// File: doc/BRIEF.md
# Piecewise-Linear Gamma Transfer Unit

This block bends a stream of 8-bit video samples through a programmable, monotonic transfer curve built from straight segments. Its purpose is to approximate gamma correction cheaply. The 256 input codes fall into eight equal segments of 32 codes each. Every segment carries a small gain code, and each gain is a slope that can be formed from shifts and additions alone, so the datapath holds no multiplier. The start level of each segment is the running total of the rises of all segments below it. The curve therefore stays continuous and can be reprogrammed at any time without rebuilding the design.

Three colour channels pass through side by side in the same cycle, and all three share one set of segment gains. A pixel word enters with a valid strobe and leaves two clocks later with its own valid strobe. A single-cycle write port loads the gain code of one segment at a time.

Top module: `gamma_pwl`

## Requirements
- R1: Each channel sample is 8 bits wide. Input bits [7:5] select the segment s (0 to 7), and bits [4:0] give the offset d within that segment (0 to 31).
- R2: A 3-bit gain code picks the slope: 0 gives 1, 1 gives 1.125, 2 gives 1.25, 3 gives 1.5, 4 gives 2 and 5 gives 4.
- R3: With G(k) the slope of segment k, the exact level is L = 32·ΣG(k) for k < s, plus d·G(s). The output is L rounded to the nearest integer, with halves rounding up.
- R4: A result greater than 255 is clamped to 255.
- R5: out_valid is high exactly two clocks after in_valid is sampled high and low two clocks after it is sampled low. Back-to-back input words give back-to-back output words.
- R6: While out_valid is low, out_pix keeps the value it last held.
- R7: Synchronous active-high reset clears out_valid and out_pix and sets every segment to gain code 0. Until the next write, each output sample equals its input sample.
- R8: When cfg_we is high at a rising edge, cfg_gain becomes the code of segment cfg_sel. A pixel sampled at that same edge still uses the old code. A pixel sampled at any later edge uses the new code.
- R9: The three channels in_pix[7:0], [15:8] and [23:16] map through the same curve independently, and each result appears in the matching field of out_pix.
- R10: Gain codes 6 and 7 behave exactly like code 0 (slope 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The input pixel word is valid this cycle |
| in_pix | input | 24 | Three 8-bit channel samples |
| cfg_we | input | 1 | Load a segment gain code this cycle |
| cfg_sel | input | 3 | Segment whose gain code is loaded |
| cfg_gain | input | 3 | Gain code to load |
| out_valid | output | 1 | The output pixel word is valid |
| out_pix | output | 24 | Three mapped 8-bit channel samples |

## Verification
Each mapped pixel word and its strobe are due on the second rising edge after the edge that samples the input. The bench drives inputs on the falling edge and keeps a two-deep shadow of what it drove. At each falling edge it compares the outputs with the entry from two falling edges earlier, and in cycles with no strobe it compares them with the last valid word. A gain write takes effect at the same edge that samples it, so the bench computes the expected value of a pixel presented with a write from the old gains, and applies the write to its model only afterwards. That pairing is exercised both directed and at random.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int PIX_W  = 8;
  localparam int SEC_W  = 3;
  localparam int OFF_W  = PIX_W - SEC_W;
  localparam int NSEC   = 1 << SEC_W;
  localparam int CODE_W = 3;
  localparam int FRAC_W = 3;
  localparam int ACC_W  = PIX_W + FRAC_W + 2;
  localparam int QUO_W  = ACC_W - FRAC_W + 1;

  typedef logic [ACC_W-1:0]  acc_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [OFF_W-1:0]  off_t;

  typedef enum code_t {
    G_1P000 = 3'd0,
    G_1P125 = 3'd1,
    G_1P250 = 3'd2,
    G_1P500 = 3'd3,
    G_2P000 = 3'd4,
    G_4P000 = 3'd5
  } gain_e;

  // slope of one code step, in eighths
  function automatic acc_t unit_slope(code_t code);
    case (code)
      G_1P125: return acc_t'(9);
      G_1P250: return acc_t'(10);
      G_1P500: return acc_t'(12);
      G_2P000: return acc_t'(16);
      G_4P000: return acc_t'(32);
      default: return acc_t'(8);
    endcase
  endfunction

  // offset times slope, in eighths, from shifts and adds only
  function automatic acc_t scale_off(off_t off, code_t code);
    acc_t a;
    a = acc_t'(off);
    case (code)
      G_1P125: return (a << 3) + a;
      G_1P250: return (a << 3) + (a << 1);
      G_1P500: return (a << 3) + (a << 2);
      G_2P000: return a << 4;
      G_4P000: return a << 5;
      default: return a << 3;
    endcase
  endfunction

  // drop the fraction with round-half-up, then clamp to full scale
  function automatic pix_t round_sat(acc_t acc);
    logic [ACC_W:0] r;
    logic [QUO_W-1:0] q;
    r = {1'b0, acc} + ((ACC_W+1)'(1) << (FRAC_W - 1));
    q = r[ACC_W:FRAC_W];
    if (q > {{(QUO_W-PIX_W){1'b0}}, {PIX_W{1'b1}}}) return {PIX_W{1'b1}};
    return q[PIX_W-1:0];
  endfunction
endpackage

// File: rtl/gamma_cfg.sv
module gamma_cfg import gamma_pkg::*; (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     we,
  input  logic [SEC_W-1:0]         sel,
  input  logic [CODE_W-1:0]        code,
  output logic [NSEC*CODE_W-1:0]   gain_flat,
  output logic [NSEC*ACC_W-1:0]    base_flat
);
  logic [NSEC*CODE_W-1:0] gain_nxt;
  logic [NSEC*ACC_W-1:0]  base_nxt;
  acc_t                   run;

  // bases follow the post-write gains so both change at the same edge
  always_comb begin
    gain_nxt = gain_flat;
    if (we) gain_nxt[sel*CODE_W +: CODE_W] = code;
    if (rst) gain_nxt = '0;
    run = '0;
    for (int s = 0; s < NSEC; s++) begin
      base_nxt[s*ACC_W +: ACC_W] = run;
      run = run + (unit_slope(gain_nxt[s*CODE_W +: CODE_W]) << OFF_W);
    end
  end

  always_ff @(posedge clk) begin
    gain_flat <= gain_nxt;
    base_flat <= base_nxt;
  end
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane import gamma_pkg::*; (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   take,
  input  logic                   fire,
  input  pix_t                   pix_in,
  input  logic [NSEC*CODE_W-1:0] gain_flat,
  input  logic [NSEC*ACC_W-1:0]  base_flat,
  output pix_t                   pix_out
);
  logic [SEC_W-1:0] sec;
  off_t             off;
  off_t             s1_off;
  code_t            s1_code;
  acc_t             s1_base;
  acc_t             level;

  assign sec = pix_in[PIX_W-1 -: SEC_W];
  assign off = pix_in[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_off  <= '0;
      s1_code <= '0;
      s1_base <= '0;
    end else if (take) begin
      s1_off  <= off;
      s1_code <= gain_flat[sec*CODE_W +: CODE_W];
      s1_base <= base_flat[sec*ACC_W +: ACC_W];
    end
  end

  assign level = s1_base + scale_off(s1_off, s1_code);

  always_ff @(posedge clk) begin
    if (rst)       pix_out <= '0;
    else if (fire) pix_out <= round_sat(level);
  end
endmodule

// File: rtl/gamma_pwl.sv
module gamma_pwl import gamma_pkg::*; #(
  parameter int NUM_CH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [NUM_CH*PIX_W-1:0] in_pix,
  input  logic                    cfg_we,
  input  logic [SEC_W-1:0]        cfg_sel,
  input  logic [CODE_W-1:0]       cfg_gain,
  output logic                    out_valid,
  output logic [NUM_CH*PIX_W-1:0] out_pix
);
  logic [NSEC*CODE_W-1:0] gain_cur;
  logic [NSEC*ACC_W-1:0]  base_cur;
  logic                   stage1_valid;

  gamma_cfg u_cfg (
    .clk       (clk),
    .rst       (rst),
    .we        (cfg_we),
    .sel       (cfg_sel),
    .code      (cfg_gain),
    .gain_flat (gain_cur),
    .base_flat (base_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_valid <= 1'b0;
      out_valid    <= 1'b0;
    end else begin
      stage1_valid <= in_valid;
      out_valid    <= stage1_valid;
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    gamma_lane u_lane (
      .clk       (clk),
      .rst       (rst),
      .take      (in_valid),
      .fire      (stage1_valid),
      .pix_in    (in_pix[ch*PIX_W +: PIX_W]),
      .gain_flat (gain_cur),
      .base_flat (base_cur),
      .pix_out   (out_pix[ch*PIX_W +: PIX_W])
    );
  end
endmodule

// File: rtl/gamma_pwl_chk.sv
module gamma_pwl_chk import gamma_pkg::*; #(
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [NUM_CH*PIX_W-1:0] in_pix,
  input logic                    cfg_we,
  input logic [SEC_W-1:0]        cfg_sel,
  input logic [CODE_W-1:0]       cfg_gain,
  input logic                    out_valid,
  input logic [NUM_CH*PIX_W-1:0] out_pix,
  input logic [NSEC*CODE_W-1:0]  gain_cur
);
  logic all_unity;

  always_comb begin
    all_unity = 1'b1;
    for (int s = 0; s < NSEC; s++) begin
      if (!(gain_cur[s*CODE_W +: CODE_W] == 3'd0 || gain_cur[s*CODE_W +: CODE_W] >= 3'd6))
        all_unity = 1'b0;
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_pix == '0)); // R7
  AST_VALID_RISE:   assert property (@(posedge clk) disable iff (rst) in_valid |-> ##2 out_valid); // R5
  AST_VALID_IDLE:   assert property (@(posedge clk) disable iff (rst) !in_valid |-> ##2 !out_valid); // R5
  AST_HOLD_IDLE:    assert property (@(posedge clk) disable iff (rst) (!out_valid && !$past(rst)) |-> $stable(out_pix)); // R6
  AST_CFG_LOAD:     assert property (@(posedge clk) disable iff (rst) cfg_we |=> (gain_cur[$past(cfg_sel)*CODE_W +: CODE_W] == $past(cfg_gain))); // R8
  AST_UNITY_PASS:   assert property (@(posedge clk) disable iff (rst) (in_valid && all_unity) |-> ##2 (out_pix == $past(in_pix, 2))); // R10
endmodule

bind gamma_pwl gamma_pwl_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/gamma_pwl_test.sv
module gamma_pwl_test;
  import gamma_pkg::*;
  localparam int NUM_CH = 3;
  localparam int W = NUM_CH * PIX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_pix = '0;
  logic cfg_we = 1'b0;
  logic [SEC_W-1:0] cfg_sel = '0;
  logic [CODE_W-1:0] cfg_gain = '0;
  logic out_valid;
  logic [W-1:0] out_pix;

  int errs = 0;
  int checks = 0;
  int gains [NSEC];
  logic hv1, hv2;
  logic [W-1:0] hd1, hd2, last_out;

  always #4 clk = ~clk;

  gamma_pwl #(.NUM_CH(NUM_CH)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_pix(in_pix),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_gain(cfg_gain),
    .out_valid(out_valid), .out_pix(out_pix)
  );

  // R2 R10: slope in eighths per code
  function automatic int eighths(int c);
    case (c)
      1: return 9;
      2: return 10;
      3: return 12;
      4: return 16;
      5: return 32;
      default: return 8;
    endcase
  endfunction

  // R1 R3 R4: reference mapping, arithmetic in integer eighths
  function automatic int map_one(int x);
    int sec, off, lvl, r;
    sec = x / 32;
    off = x % 32;
    lvl = 0;
    for (int k = 0; k < sec; k++) lvl += 32 * eighths(gains[k]);
    lvl += off * eighths(gains[sec]);
    r = (lvl + 4) / 8;
    return (r > 255) ? 255 : r;
  endfunction

  function automatic logic [W-1:0] map_all(logic [W-1:0] p);
    logic [W-1:0] o;
    for (int ch = 0; ch < NUM_CH; ch++) o[ch*PIX_W +: PIX_W] = PIX_W'(map_one(int'(p[ch*PIX_W +: PIX_W])));
    return o;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  // one cycle: check what is due now, then drive the next inputs
  task automatic cyc(bit v, logic [W-1:0] p, bit we, int sel, int g);
    @(negedge clk);
    chk("R5 out_valid latency", int'(out_valid), int'(hv2));
    if (hv2) begin
      for (int ch = 0; ch < NUM_CH; ch++)
        chk("R3 R9 channel result", int'(out_pix[ch*PIX_W +: PIX_W]), int'(hd2[ch*PIX_W +: PIX_W]));
    end else begin
      chk("R6 hold while idle", int'(out_pix), int'(last_out));
    end
    if (out_valid) last_out = out_pix;
    hv2 = hv1;
    hd2 = hd1;
    hv1 = v;
    hd1 = v ? map_all(p) : '0;
    in_valid = v;
    in_pix   = p;
    cfg_we   = we;
    cfg_sel  = SEC_W'(sel);
    cfg_gain = CODE_W'(g);
    if (we) gains[sel] = g;  // R8: the write reaches only later pixels
  endtask

  task automatic pix3(int a, int b, int c);
    cyc(1'b1, {PIX_W'(c), PIX_W'(b), PIX_W'(a)}, 1'b0, 0, 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 reset out_valid", int'(out_valid), 0);
    chk("R7 reset out_pix", int'(out_pix), 0);
    rst = 1'b0;
    hv1 = 1'b0; hv2 = 1'b0; hd1 = '0; hd2 = '0; last_out = '0;
    for (int s = 0; s < NSEC; s++) gains[s] = 0;
  endtask

  task automatic flush();
    repeat (3) cyc(1'b0, '0, 1'b0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R5 watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    do_reset();

    // R7 R1: identity after reset, segment edges included
    pix3(0, 31, 32);
    pix3(255, 224, 223);
    for (int i = 0; i < 40; i++) cyc(1'b1, W'($urandom), 1'b0, 0, 0);
    flush();

    // R2 R3: one code per segment, boundaries on either side of each edge
    for (int s = 0; s < NSEC; s++) cyc(1'b0, '0, 1'b1, s, s % 6);
    for (int s = 0; s < NSEC; s++) pix3(s * 32, s * 32 + 31, s * 32 + 16);
    pix3(1, 33, 67);
    flush();

    // R4: steepest slope everywhere drives the top into clamp
    for (int s = 0; s < NSEC; s++) cyc(1'b0, '0, 1'b1, s, 5);
    pix3(63, 64, 255);
    pix3(32, 100, 200);
    flush();

    // R10: codes 6 and 7 match slope 1
    for (int s = 0; s < NSEC; s++) cyc(1'b0, '0, 1'b1, s, 6 + (s % 2));
    pix3(17, 129, 250);
    flush();

    // R8: write and pixel in one cycle, then pixel right after
    cyc(1'b1, {8'd20, 8'd10, 8'd5}, 1'b1, 0, 5);
    pix3(5, 10, 20);
    cyc(1'b1, {8'd40, 8'd36, 8'd33}, 1'b1, 1, 3);
    pix3(33, 36, 40);
    flush();

    // R5 R6 R8 R9: random valid gaps, back-to-back runs, random writes
    for (int i = 0; i < 3000; i++)
      cyc(($urandom % 4) != 0, W'($urandom), ($urandom % 8) == 0, int'($urandom % NSEC), int'($urandom % 8));
    flush();

    // R7: reset in the middle restores identity
    for (int s = 0; s < NSEC; s++) cyc(1'b0, '0, 1'b1, s, 4);
    do_reset();
    pix3(77, 150, 201);
    for (int i = 0; i < 20; i++) cyc(1'b1, W'($urandom), 1'b0, 0, 0);
    flush();

    summary();
    $finish;
  end
endmodule